// File: doc/BRIEF.md
# Scratch Memory Load/Store Unit

This unit moves data between a 24-bit staging register and two on-chip stores: a 3072-byte read/write scratch RAM and a 1024-word, 24-bit read-only table. One operation is accepted per clock. A RAM access moves a single byte between the RAM and one byte lane of the staging register. A table read loads a full 24-bit word into a separate result register.

A RAM address comes from one of two sources. In register mode it is the low 12 bits of a 24-bit address operand. In page mode it is a 12-bit page register plus an 8-bit offset, with the sum wrapping in 12 bits. The 12-bit space is larger than the RAM, so any address in the top window is folded down onto the RAM before the access. The table contents are loaded through a dedicated fill port, which is separate from the operational read path.

Top module: `memacc_top`

## Requirements
- R1: With `useImm`=0, a RAM operation addresses the low 12 bits of `addrReg`; bits 23:12 are ignored.
- R2: With `useImm`=1, a RAM operation addresses (page register + `imm[7:0]`) truncated to 12 bits.
- R3: An address of 0xC00 or above has 0x400 subtracted before the RAM is accessed, so 0xC00..0xFFF alias 0x800..0xBFF.
- R4: RAM read (`opCode`=1) replaces only lane `byteSel` of the staging register, where lane k is bits 8k+7:8k. The other two lanes keep their values.
- R5: RAM write (`opCode`=2) stores lane `byteSel` of the staging register into the addressed RAM byte.
- R6: Table read (`opCode`=3) loads the word at index `addrReg[9:0]` (`useImm`=0) or `imm[9:0]` (`useImm`=1) into `romOut`. No other operation changes `romOut`.
- R7: Clear (`opCode`=4) zeroes the staging register and the page register and leaves `romOut` unchanged.
- R8: A `byteSel` of 3 makes a RAM read leave the staging register unchanged and makes a RAM write store nothing.
- R9: After reset, `stageOut`, `romOut` and `pageOut` are zero.
- R10: Set-page (`opCode`=5) loads `addrReg[11:0]` into the page register. Set-stage (`opCode`=6) loads `addrReg` into the staging register. `opCode`=0 and `opValid`=0 change nothing.
- R11: An operation sampled on a rising edge shows its result on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 3 | Operation code (see R4 to R10) |
| useImm | input | 1 | Select the page/immediate address source |
| byteSel | input | 2 | Staging register byte lane |
| addrReg | input | 24 | Register operand: address, index or load value |
| imm | input | 10 | Immediate offset or table index |
| romWrEn | input | 1 | Table fill write enable |
| romWrAddr | input | 10 | Table fill index |
| romWrData | input | 24 | Table fill data |
| stageOut | output | 24 | Staging register |
| romOut | output | 24 | Table result register |
| pageOut | output | 12 | Page register |

## Verification
The assertions assume that `opCode` carries only the seven defined codes while `opValid` is high, and that the table is filled before any table read. They also assume the fill port is never used in the same cycle as a table read. The bench fills all 1024 table entries while reset is held, then issues only defined operations with the fill port idle. The addresses it picks sit on both sides of the fold boundary and include a page sum that overflows 12 bits.

// File: rtl/memacc_pkg.sv
package memacc_pkg;
  parameter int DATA_W    = 24;
  parameter int LANE_W    = 8;
  parameter int LANES     = DATA_W / LANE_W;
  parameter int ADDR_W    = 12;
  parameter int OFS_W     = 8;
  parameter int ROM_AW    = 10;
  parameter int ROM_DEPTH = 1 << ROM_AW;
  parameter int FOLD_BASE = 'hC00;
  parameter int FOLD_OFF  = 'h400;
  parameter int RAM_BYTES = FOLD_BASE;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_RAM_RD   = 3'd1,
    OP_RAM_WR   = 3'd2,
    OP_ROM_RD   = 3'd3,
    OP_CLEAR    = 3'd4,
    OP_SETPAGE  = 3'd5,
    OP_SETSTAGE = 3'd6
  } op_e;

  typedef struct packed {
    logic              ramRd;
    logic              ramWr;
    logic              romRd;
    logic              clr;
    logic              setPage;
    logic              setStage;
    logic [1:0]        lane;
    logic [ADDR_W-1:0] ramAddr;
    logic [ROM_AW-1:0] romIdx;
  } strobe_t;
endpackage

// File: rtl/memacc_ctrl.sv
module memacc_ctrl
  import memacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic              useImm,
  input  logic [1:0]        byteSel,
  input  logic [DATA_W-1:0] addrReg,
  input  logic [ROM_AW-1:0] imm,
  input  logic [ADDR_W-1:0] pageReg,
  output strobe_t           strobe
);
  logic [ADDR_W-1:0] rawAddr;
  logic [ADDR_W-1:0] foldAddr;
  logic              laneOk;

  always_comb begin
    if (useImm) rawAddr = pageReg + ADDR_W'(imm[OFS_W-1:0]);
    else        rawAddr = addrReg[ADDR_W-1:0];
    if (rawAddr >= ADDR_W'(FOLD_BASE)) foldAddr = rawAddr - ADDR_W'(FOLD_OFF);
    else                               foldAddr = rawAddr;
  end

  assign laneOk = (32'(byteSel) < LANES);

  always_comb begin
    strobe          = '0;
    strobe.lane     = byteSel;
    strobe.ramAddr  = foldAddr;
    strobe.romIdx   = useImm ? imm : addrReg[ROM_AW-1:0];
    if (opValid) begin
      strobe.ramRd    = (opCode == OP_RAM_RD) && laneOk;
      strobe.ramWr    = (opCode == OP_RAM_WR) && laneOk;
      strobe.romRd    = (opCode == OP_ROM_RD);
      strobe.clr      = (opCode == OP_CLEAR);
      strobe.setPage  = (opCode == OP_SETPAGE);
      strobe.setStage = (opCode == OP_SETSTAGE);
    end
  end

  // R3: every RAM access lands inside the physical RAM
  a_r3_addr_in_ram: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ramRd || strobe.ramWr) |-> (32'(strobe.ramAddr) < RAM_BYTES));

  // R8: lane 3 never produces a transfer strobe
  a_r8_no_lane3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && byteSel == 2'd3) |-> !(strobe.ramRd || strobe.ramWr));
endmodule

// File: rtl/memacc_datapath.sv
module memacc_datapath
  import memacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] setValue,
  input  logic              romWrEn,
  input  logic [ROM_AW-1:0] romWrAddr,
  input  logic [DATA_W-1:0] romWrData,
  output logic [DATA_W-1:0] stageReg,
  output logic [DATA_W-1:0] romReg,
  output logic [ADDR_W-1:0] pageReg
);
  logic [LANE_W-1:0] ramMem [RAM_BYTES];
  logic [DATA_W-1:0] romMem [ROM_DEPTH];
  logic [LANE_W-1:0] ramRdByte;
  logic [LANE_W-1:0] wrByte;

  assign ramRdByte = ramMem[strobe.ramAddr];

  always_comb begin
    wrByte = '0;
    for (int k = 0; k < LANES; k++)
      if (32'(strobe.lane) == k) wrByte = stageReg[k*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk)
    if (strobe.ramWr) ramMem[strobe.ramAddr] <= wrByte;

  always_ff @(posedge clk)
    if (romWrEn) romMem[romWrAddr] <= romWrData;

  always_ff @(posedge clk) begin
    if (!rstN)             romReg <= '0;
    else if (strobe.romRd) romReg <= romMem[strobe.romIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clr) pageReg <= '0;
    else if (strobe.setPage) pageReg <= setValue[ADDR_W-1:0];
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      always_ff @(posedge clk) begin
        if (!rstN || strobe.clr)
          stageReg[g*LANE_W +: LANE_W] <= '0;
        else if (strobe.setStage)
          stageReg[g*LANE_W +: LANE_W] <= setValue[g*LANE_W +: LANE_W];
        else if (strobe.ramRd && 32'(strobe.lane) == g)
          stageReg[g*LANE_W +: LANE_W] <= ramRdByte;
      end
    end
  endgenerate

  // R4: a lane-0 read keeps the upper lanes
  a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ramRd && strobe.lane == 2'd0) |=> (stageReg[DATA_W-1:LANE_W] == $past(stageReg[DATA_W-1:LANE_W])));

  // R6: only a table read moves romReg
  a_r6_rom_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.romRd |=> $stable(romReg));

  // R7: clear empties stage and page
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (stageReg == '0 && pageReg == '0));

  // R10: set-stage takes the operand
  a_r10_setstage: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setStage && !strobe.clr) |=> (stageReg == $past(setValue)));
endmodule

// File: rtl/memacc_top.sv
module memacc_top
  import memacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic              useImm,
  input  logic [1:0]        byteSel,
  input  logic [23:0]       addrReg,
  input  logic [9:0]        imm,
  input  logic              romWrEn,
  input  logic [9:0]        romWrAddr,
  input  logic [23:0]       romWrData,
  output logic [23:0]       stageOut,
  output logic [23:0]       romOut,
  output logic [11:0]       pageOut
);
  strobe_t           strobe;
  logic [ADDR_W-1:0] pageReg;

  memacc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .useImm(useImm), .byteSel(byteSel), .addrReg(addrReg), .imm(imm),
    .pageReg(pageReg), .strobe(strobe)
  );

  memacc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .setValue(addrReg),
    .romWrEn(romWrEn), .romWrAddr(romWrAddr), .romWrData(romWrData),
    .stageReg(stageOut), .romReg(romOut), .pageReg(pageReg)
  );

  assign pageOut = pageReg;
endmodule

// File: tb/memacc_top_bench.sv
module memacc_top_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic        opValid = 0;
  logic [2:0]  opCode = 0;
  logic        useImm = 0;
  logic [1:0]  byteSel = 0;
  logic [23:0] addrReg = 0;
  logic [9:0]  imm = 0;
  logic        romWrEn = 0;
  logic [9:0]  romWrAddr = 0;
  logic [23:0] romWrData = 0;
  logic [23:0] stageOut, romOut;
  logic [11:0] pageOut;

  memacc_top u_memacc_top (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    logic [23:0] stage;
    logic [23:0] rom;
    logic [11:0] page;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int          checks = 0, failures = 0;
  bit          done = 0;
  logic [7:0]  mRam [3072];
  logic [23:0] mStage = 0, mRom = 0;
  logic [11:0] mPage = 0;

  function automatic logic [23:0] romVal(int i);
    return 24'((i * 24'h0009E3 + 24'h00005A) ^ (i << 12));
  endfunction

  function automatic int foldA(logic [11:0] a);
    return (a >= 12'hC00) ? int'(a) - 'h400 : int'(a);
  endfunction

  task automatic check(string tag, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doOp(logic [2:0] op, logic ui, logic [1:0] bs, logic [23:0] ar,
                      logic [9:0] im, string tag);
    int a;
    @(negedge clk);
    opValid = 1; opCode = op; useImm = ui; byteSel = bs; addrReg = ar; imm = im;
    a = foldA(ui ? 12'(mPage + 12'(im[7:0])) : ar[11:0]);
    case (op)
      3'd1: if (bs != 3) mStage[bs*8 +: 8] = mRam[a];
      3'd2: if (bs != 3) mRam[a] = mStage[bs*8 +: 8];
      3'd3: mRom = romVal(ui ? int'(im) : int'(ar[9:0]));
      3'd4: begin mStage = 0; mPage = 0; end
      3'd5: mPage = ar[11:0];
      3'd6: mStage = ar;
      default: ;
    endcase
    @(posedge clk);
    #1;
    sbq.push_back('{mStage, mRom, mPage, tag});
  endtask

  // monitor
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check(e.tag, "stage", stageOut, e.stage);
      check(e.tag, "rom", romOut, e.rom);
      check(e.tag, "page", {12'h0, pageOut}, {12'h0, e.page});
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3072; i++) mRam[i] = 8'hxx;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      romWrEn = 1; romWrAddr = 10'(i); romWrData = romVal(i);
    end
    @(negedge clk);
    romWrEn = 0;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R9", "stage", stageOut, 24'h0);
    check("R9", "rom", romOut, 24'h0);
    check("R9", "page", {12'h0, pageOut}, 24'h0);

    doOp(3'd6, 0, 0, 24'hA1B2C3, 0, "R10 setstage");
    // R5 R1: writes with register addressing, high operand bits ignored
    doOp(3'd2, 0, 0, 24'hFF0123, 0, "R5 R1 wr lane0");
    doOp(3'd2, 0, 1, 24'h000124, 0, "R5 wr lane1");
    doOp(3'd2, 0, 2, 24'h000BFF, 0, "R5 wr lane2 top");
    doOp(3'd2, 0, 0, 24'h000805, 0, "R5 wr 0x805");
    // R3: 0xC05 aliases 0x805 and overwrites it
    doOp(3'd2, 0, 2, 24'h000C05, 0, "R3 wr alias");
    doOp(3'd6, 0, 0, 24'h000000, 0, "R10 zero stage");
    doOp(3'd1, 0, 1, 24'h000805, 0, "R3 rd 0x805");
    doOp(3'd1, 0, 0, 24'h000FFF, 0, "R3 rd 0xFFF->0xBFF");
    doOp(3'd1, 0, 2, 24'h7A0123, 0, "R4 R1 rd lane2");
    // R8: lane 3
    doOp(3'd1, 0, 3, 24'h000123, 0, "R8 rd lane3");
    doOp(3'd2, 0, 3, 24'h000124, 0, "R8 wr lane3");
    doOp(3'd1, 0, 0, 24'h000124, 0, "R8 rd back 0x124");
    // R2: page addressing
    doOp(3'd5, 0, 0, 24'hFFFBF0, 0, "R10 setpage");
    doOp(3'd6, 0, 0, 24'h5E6F70, 0, "R10 setstage2");
    doOp(3'd2, 1, 1, 0, 10'h320, "R2 R3 wr page 0xC10");
    doOp(3'd1, 0, 0, 24'h000810, 0, "R2 R3 rd 0x810");
    doOp(3'd5, 0, 0, 24'h000FF0, 0, "R10 setpage2");
    doOp(3'd2, 1, 2, 0, 10'h020, "R2 wr wrap 0x010");
    doOp(3'd1, 0, 1, 24'h000010, 0, "R2 rd 0x010");
    doOp(3'd1, 1, 0, 0, 10'h133, "R2 rd page+0x33");
    // R6: table reads
    doOp(3'd3, 0, 0, 24'hABC3FF, 0, "R6 rom reg");
    doOp(3'd3, 1, 0, 24'h000000, 10'h2A5, "R6 rom imm");
    doOp(3'd0, 0, 0, 24'h000001, 0, "R10 nop");
    doOp(3'd6, 0, 0, 24'h123456, 0, "R6 hold on setstage");
    // R7
    doOp(3'd4, 0, 0, 24'hFFFFFF, 0, "R7 clear");
    doOp(3'd1, 0, 1, 24'h000123, 0, "R11 rd after clear");
    @(negedge clk);
    opValid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule